// File: doc/BRIEF.md
# Interrupt Source Mapping Unit

This block sits in the digital core of a radio transceiver. It drives the IRQ1 interrupt line and keeps two sticky status flags: one for the received signal strength and one for PLL lock. The 2-bit data mode and a source-select bit decide what IRQ1 carries. In continuous mode the data clock goes straight through to the line. In buffered and packet modes IRQ1 carries either a FIFO-full event or a transmit-done event. Transmit-done means the last bit has left the transmit shift register.

The signal-strength flag sets when a strobed RSSI sample is strictly greater than a programmable threshold. The PLL flag sets when the lock input rises. Software clears either flag by writing 1 to its bit. A separate enable gates each flag source. The lock-detect pin shows the synchronized lock state when its enable is set, and is held high when the enable is clear. The lock input and the two event inputs are asynchronous, so each passes through a two-flop synchronizer before the block uses it.

Top module: `irq_route_unit`

## Requirements
- R1: After reset the source select is 0, the RSSI enable is 0, the lock-detect enable is 1, the threshold is 0 and both sticky flags read 0.
- R2: While `data_mode` is 00, `irq1` follows `dclk` combinationally, whatever the source select is.
- R3: While `data_mode` is 01, 10 or 11 and the source select is 0, `irq1` follows the synchronized FIFO-full input. This level is also readable on `status[2]`.
- R4: While `data_mode` is 01, 10 or 11 and the source select is 1, `irq1` follows the synchronized transmit-done input. This level is also readable on `status[3]`.
- R5: When `rssi_strobe` is high and the RSSI enable is 1, the RSSI flag (`status[0]`) sets on that clock edge if `rssi_val` is strictly greater than the threshold, compared as unsigned numbers. A sample equal to or below the threshold does not set the flag.
- R6: While the RSSI enable is 0, no strobed sample sets the RSSI flag.
- R7: The PLL flag (`status[1]`) sets on a rising edge of the synchronized `pll_lock_in`. It stays set after the lock input falls, until it is cleared.
- R8: A write to address 2 clears each flag whose data bit is 1: bit 0 clears the RSSI flag and bit 1 clears the PLL flag. A data bit of 0 leaves its flag unchanged.
- R9: If a flag's set condition and its write-1 clear fall on the same edge, the flag is set afterwards.
- R10: When the lock-detect enable is 1, `lock_pin` shows the synchronized lock state. When the enable is 0, `lock_pin` is held at 1.
- R11: The register map is as follows. Address 0 holds the control bits: bit 0 is the source select, bit 1 is the RSSI enable and bit 2 is the lock-detect enable. Address 1 holds the threshold. A write to address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | RSSI_W | Write data |
| data_mode | input | 2 | Data mode: 00 continuous, 01 buffered, 1x packet |
| fifo_full_in | input | 1 | Asynchronous FIFO-full level |
| tx_done_in | input | 1 | Asynchronous transmit-done level |
| dclk | input | 1 | Data clock, forwarded in continuous mode |
| rssi_val | input | RSSI_W | RSSI sample |
| rssi_strobe | input | 1 | New-sample strobe |
| pll_lock_in | input | 1 | Asynchronous PLL lock indication |
| irq1 | output | 1 | Interrupt line |
| lock_pin | output | 1 | Lock-detect pin |
| status | output | 4 | {tx_done sync, fifo_full sync, PLL flag, RSSI flag} |

## Verification
The hardest case to reach is a flag set and its clear landing on the same edge. To get there, the bench drives a strobe above the threshold in the same cycle as a write-1 clear, so both act on one edge. The threshold comparison is swept over every sample value against the thresholds at both ends of the range and at its middle, so that the strict-greater boundary and the unsigned ordering are both exercised. The IRQ1 mux is swept over every combination of mode, select, data clock and event levels.

// File: rtl/irq_route_unit.sv
module irq_route_unit #(
  parameter int RSSI_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [RSSI_W-1:0] wr_data,
  input  logic [1:0]        data_mode,
  input  logic              fifo_full_in,
  input  logic              tx_done_in,
  input  logic              dclk,
  input  logic [RSSI_W-1:0] rssi_val,
  input  logic              rssi_strobe,
  input  logic              pll_lock_in,
  output logic              irq1,
  output logic              lock_pin,
  output logic [3:0]        status
);
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_THR  = 2'd1;
  localparam logic [1:0] A_CLR  = 2'd2;

  logic [2:0] meta, sync;
  logic lock_q, sel, rssi_en, lock_en, rssi_flag, pll_flag;
  logic [RSSI_W-1:0] thr;

  wire ff_s   = sync[0];
  wire txd_s  = sync[1];
  wire lock_s = sync[2];

  wire wr_ctrl = wr_en && wr_addr == A_CTRL;
  wire wr_thr  = wr_en && wr_addr == A_THR;
  wire wr_clr  = wr_en && wr_addr == A_CLR;

  wire rssi_set = rssi_strobe && rssi_en && (rssi_val > thr);
  wire pll_set  = lock_s && !lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta      <= '0;
      sync      <= '0;
      lock_q    <= 1'b0;
      sel       <= 1'b0;
      rssi_en   <= 1'b0;
      lock_en   <= 1'b1;
      thr       <= '0;
      rssi_flag <= 1'b0;
      pll_flag  <= 1'b0;
    end else begin
      meta   <= {pll_lock_in, tx_done_in, fifo_full_in};
      sync   <= meta;
      lock_q <= lock_s;
      if (wr_ctrl) begin
        sel     <= wr_data[0];
        rssi_en <= wr_data[1];
        lock_en <= wr_data[2];
      end
      if (wr_thr) thr <= wr_data;
      rssi_flag <= rssi_set | (rssi_flag & ~(wr_clr & wr_data[0]));
      pll_flag  <= pll_set  | (pll_flag  & ~(wr_clr & wr_data[1]));
    end
  end

  assign irq1     = (data_mode == 2'b00) ? dclk : (sel ? txd_s : ff_s);
  assign lock_pin = lock_en ? lock_s : 1'b1;
  assign status   = {txd_s, ff_s, pll_flag, rssi_flag};
endmodule

module irq_route_chk #(
  parameter int RSSI_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [1:0]        wr_addr,
  input logic [RSSI_W-1:0] wr_data,
  input logic [1:0]        data_mode,
  input logic              dclk,
  input logic [RSSI_W-1:0] rssi_val,
  input logic              rssi_strobe,
  input logic              irq1,
  input logic              lock_pin,
  input logic [3:0]        status,
  input logic              rssi_en,
  input logic              lock_en,
  input logic [RSSI_W-1:0] thr
);
  wire clr0 = wr_en && wr_addr == 2'd2 && wr_data[0];
  wire clr1 = wr_en && wr_addr == 2'd2 && wr_data[1];

  // R2
  cont_mode_dclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_mode == 2'b00) |-> (irq1 == dclk));

  // R5
  rssi_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[0]) |-> $past(rssi_strobe && rssi_en && (rssi_val > thr)));

  // R6
  rssi_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rssi_en && !status[0]) |=> !status[0]);

  // R7
  pll_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[1] && !clr1) |=> status[1]);

  // R9
  rssi_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rssi_strobe && rssi_en && (rssi_val > thr) && clr0) |=> status[0]);

  // R10
  lock_pin_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_en |-> lock_pin);
endmodule

bind irq_route_unit irq_route_chk #(.RSSI_W(RSSI_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .data_mode(data_mode), .dclk(dclk), .rssi_val(rssi_val), .rssi_strobe(rssi_strobe),
  .irq1(irq1), .lock_pin(lock_pin), .status(status), .rssi_en(rssi_en),
  .lock_en(lock_en), .thr(thr)
);

// File: tb/irq_route_unit_tb.sv
module irq_route_unit_tb;
  localparam int W = 8;
  logic clk = 0, rst_n = 0, wr_en = 0, fifo_full_in = 0, tx_done_in = 0, dclk = 0;
  logic rssi_strobe = 0, pll_lock_in = 0;
  logic [1:0] wr_addr = 0, data_mode = 0;
  logic [W-1:0] wr_data = 0, rssi_val = 0;
  logic irq1, lock_pin;
  logic [3:0] status;
  int total = 0, bad = 0, cyc = 0;
  bit done = 0;
  logic [2:0] ctrl = 3'b100;

  irq_route_unit #(.RSSI_W(W)) u_dut (.*);

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1; bad++; total++;
      $display("FAIL watchdog expired act=%0d exp=<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string rq, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_data = 0;
  endtask

  task automatic setctrl(input logic [2:0] c);
    ctrl = c;
    wr(2'd0, W'(c));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(2);
    rst_n = 1;
    idle(1);
    // R1 reset state
    chk("R1 flags", status[1:0], 0);
    chk("R1 lock pin enabled shows low lock", lock_pin, 0);
    data_mode = 2'b01; fifo_full_in = 1; idle(3);
    chk("R1 select defaults to fifo-full", irq1, 1);
    fifo_full_in = 0; idle(3);

    // R2 R3 R4 sweep
    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 2; s++) begin
        setctrl({1'b1, 1'b0, s[0]});
        for (int v = 0; v < 8; v++) begin
          data_mode = m[1:0];
          dclk = v[0]; fifo_full_in = v[1]; tx_done_in = v[2];
          idle(3);
          if (m == 0) chk("R2 dclk forward", irq1, v[0]);
          else if (s == 0) chk("R3 fifo-full route", irq1, v[1]);
          else chk("R4 tx-done route", irq1, v[2]);
          chk("R3 R4 status levels", status[3:2], {v[2], v[1]});
        end
      end
    dclk = 0; fifo_full_in = 0; tx_done_in = 0; idle(3);

    // R5 R6 R11 threshold sweep
    foreach (ctrl[i]) ;
    for (int e = 0; e < 2; e++) begin
      setctrl({1'b1, e[0], 1'b0});
      for (int t = 0; t < 4; t++) begin
        automatic int th = (t == 0) ? 0 : (t == 1) ? 127 : (t == 2) ? 128 : 255;
        wr(2'd1, W'(th));
        for (int v = 0; v < 256; v++) begin
          rssi_strobe = 1; rssi_val = W'(v);
          @(negedge clk);
          rssi_strobe = 0;
          if (e == 1) chk("R5 strict compare", status[0], (v > th) ? 1 : 0);
          else chk("R6 disabled never sets", status[0], 0);
          if (status[0]) begin
            wr(2'd2, W'(1));
            chk("R8 clear rssi", status[0], 0);
          end
        end
      end
    end
    // R9 set wins
    setctrl(3'b110);
    wr(2'd1, W'(10));
    rssi_strobe = 1; rssi_val = W'(11);
    wr(2'd2, W'(1));
    rssi_strobe = 0;
    chk("R9 set wins over clear", status[0], 1);
    // R8 write 0 keeps
    wr(2'd2, W'(2));
    chk("R8 bit0=0 keeps rssi flag", status[0], 1);
    // R11 addr 3 ignored
    wr(2'd3, W'(8'hFF));
    rssi_strobe = 1; rssi_val = W'(10); idle(1); rssi_strobe = 0;
    wr(2'd2, W'(1));
    rssi_strobe = 1; rssi_val = W'(10); idle(1); rssi_strobe = 0;
    chk("R11 addr3 write left threshold", status[0], 0);
    chk("R11 addr3 write left lock enable", lock_pin, 0);

    // R7 R10
    pll_lock_in = 1; idle(4);
    chk("R7 pll flag sets", status[1], 1);
    chk("R10 lock pin follows", lock_pin, 1);
    pll_lock_in = 0; idle(4);
    chk("R7 pll flag sticky", status[1], 1);
    chk("R10 lock pin low", lock_pin, 0);
    wr(2'd2, W'(1));
    chk("R8 bit1=0 keeps pll flag", status[1], 1);
    wr(2'd2, W'(2));
    chk("R8 clear pll", status[1], 0);
    setctrl(3'b010);
    chk("R10 disabled pin high", lock_pin, 1);
    pll_lock_in = 1; idle(4);
    chk("R10 disabled pin high locked", lock_pin, 1);
    chk("R7 flag independent of pin enable", status[1], 1);
    pll_lock_in = 0; idle(4);
    pll_lock_in = 1; idle(2);
    wr(2'd2, W'(2));
    chk("R9 pll set wins over clear", status[1], 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule